// File: doc/BRIEF.md
# Boot Mode and Processor Reset Sequencer

This block chooses the 4-bit boot-mode code presented to an application processor and controls that processor's active-low reset and the system power-enable line. The mode comes from one of four places. A 3-bit carrier select field is decoded through a fixed table that falls back to a default. A command byte can name a mode directly. An active-low recovery strap forces serial download. A long press of the reset button also forces serial download.

After power-up, reset is held low for a startup delay and is then released. A restart, whether from a command or from the button, pulls reset low for a minimum pulse and then runs the same startup delay again. While reset is low, the mode bus settles to its new value. While the processor runs, the mode bus stays frozen. A power-off command drops the power enable. A later button release powers the system back on through a normal restart.

The command arrives as a one-cycle strobe with a byte, taken from a register write that is decoded elsewhere. All delays are parameters counted in clock cycles.

Top module: `boot_reset_seq`

## Requirements
- R1: When the mode follows the select field, select 3'b001 gives mode 4'b0011, 3'b100 gives 4'b0000, 3'b101 gives 4'b0001 and 3'b110 gives 4'b0010. The select field is sampled on every cycle while reset is low.
- R2: Every other select value (000, 010, 011, 111) gives mode 4'b0000.
- R3: While `recov_n_i` is low, `boot_mode_o` is 4'b0001 in the same cycle, whatever the select field or command. When the pin goes high again, the previously chosen mode returns.
- R4: After `rst_n` is released, `cpu_rst_n_o` stays low for exactly STARTUP_CYC cycles and then goes high. `pwr_en_o` is high and the mode follows the select field.
- R5: Command bytes 0x00, 0x01, 0x02 and 0x03 restart the processor with mode 4'b0000, 4'b0001, 4'b0010 and 4'b0011 respectively. Reset is low for exactly PULSE_CYC + STARTUP_CYC cycles, counted from the cycle after the strobe.
- R6: Command byte 0x05 restarts the processor with the same timing as R5, with the mode taken from the select field.
- R7: Command byte 0x04 drives `pwr_en_o` and `cpu_rst_n_o` low from the next cycle. While the system is off, commands are ignored. A button release restarts it with power on, using the R5 timing.
- R8: Command bytes 0x06 to 0xFF have no effect on reset, power or the mode bus.
- R9: If the button is held high for HOLD_CYC cycles or more and then released, the processor restarts with the R5 timing into mode 4'b0001.
- R10: If the button is released after fewer than HOLD_CYC cycles, the processor restarts with the R5 timing into the select-field mode.
- R11: While `cpu_rst_n_o` is high, changes on the select field do not change `boot_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sel_i | input | 3 | Carrier boot-select field |
| recov_n_i | input | 1 | Active-low forced-recovery strap |
| btn_i | input | 1 | Debounced reset button, high while pressed |
| cmd_vld_i | input | 1 | One-cycle command strobe |
| cmd_byte_i | input | 8 | Control code carried by the strobe |
| boot_mode_o | output | 4 | Boot-mode code to the processor |
| cpu_rst_n_o | output | 1 | Active-low processor reset |
| pwr_en_o | output | 1 | System power enable |

## Verification
The bench builds the block with STARTUP_CYC = 20, PULSE_CYC = 5 and HOLD_CYC = 50. At these values the reset pulse can be measured to the exact cycle after power-up, after commands and after button releases. They also bring the long-press threshold within a few dozen cycles. The button is then held for exactly HOLD_CYC and HOLD_CYC - 1 cycles, so both sides of the boundary are exercised.

// File: rtl/boot_reset_seq.sv
module boot_reset_seq #(
  parameter int unsigned STARTUP_CYC = 12_500_000,
  parameter int unsigned PULSE_CYC   = 125_000,
  parameter int unsigned HOLD_CYC    = 1_250_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       recov_n_i,
  input  logic       btn_i,
  input  logic       cmd_vld_i,
  input  logic [7:0] cmd_byte_i,
  output logic [3:0] boot_mode_o,
  output logic       cpu_rst_n_o,
  output logic       pwr_en_o
);

  localparam int unsigned SEQ_MAX = (STARTUP_CYC > PULSE_CYC) ? STARTUP_CYC : PULSE_CYC;
  localparam int CW = $clog2(SEQ_MAX + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] START_LAST = CW'(STARTUP_CYC - 1);
  localparam logic [HW-1:0] HOLD_LIM   = HW'(HOLD_CYC);
  localparam logic [3:0]    MODE_SDP   = 4'b0001;

  typedef enum logic [1:0] {ST_PULSE, ST_WAIT, ST_RUN, ST_OFF} seq_t;

  seq_t          state;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hold_cnt;
  logic [3:0]    mode_q;
  logic [3:0]    sel_mode;
  logic          follow_sel;
  logic          btn_q;

  always_comb begin
    case (sel_i)
      3'b001:  sel_mode = 4'b0011;
      3'b100:  sel_mode = 4'b0000;
      3'b101:  sel_mode = 4'b0001;
      3'b110:  sel_mode = 4'b0010;
      default: sel_mode = 4'b0000;
    endcase
  end

  wire powered     = (state != ST_OFF);
  wire cmd_off     = cmd_vld_i && powered && (cmd_byte_i == 8'h04);
  wire cmd_restart = cmd_vld_i && powered && (cmd_byte_i <= 8'h05) && (cmd_byte_i != 8'h04);
  wire btn_rel     = btn_q && !btn_i;
  wire long_hold   = (hold_cnt >= HOLD_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_WAIT;
      cnt        <= '0;
      mode_q     <= 4'b0000;
      follow_sel <= 1'b1;
      btn_q      <= 1'b0;
      hold_cnt   <= '0;
    end else begin
      btn_q <= btn_i;
      if (btn_i) begin
        if (hold_cnt != HOLD_LIM) hold_cnt <= hold_cnt + 1'b1;
      end else begin
        hold_cnt <= '0;
      end

      if (cmd_off) begin
        state <= ST_OFF;
        cnt   <= '0;
      end else if (cmd_restart) begin
        state      <= ST_PULSE;
        cnt        <= '0;
        follow_sel <= (cmd_byte_i == 8'h05);
        if (cmd_byte_i != 8'h05) mode_q <= {2'b00, cmd_byte_i[1:0]};
      end else if (btn_rel) begin
        state      <= ST_PULSE;
        cnt        <= '0;
        follow_sel <= !long_hold;
        if (long_hold) mode_q <= MODE_SDP;
      end else begin
        case (state)
          ST_PULSE: begin
            if (follow_sel) mode_q <= sel_mode;
            if (cnt == PULSE_LAST) begin
              state <= ST_WAIT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WAIT: begin
            if (follow_sel) mode_q <= sel_mode;
            if (cnt == START_LAST) begin
              state <= ST_RUN;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cpu_rst_n_o = (state == ST_RUN);
  assign pwr_en_o    = powered;
  assign boot_mode_o = recov_n_i ? mode_q : MODE_SDP;

  AST_RUN_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_n_o && $past(cpu_rst_n_o) && recov_n_i && $past(recov_n_i)) |-> $stable(boot_mode_o)); // R11

  AST_CMD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && cmd_byte_i < 8'h04 && pwr_en_o && recov_n_i) |=>
      (!cpu_rst_n_o && (!recov_n_i || boot_mode_o == {2'b00, $past(cmd_byte_i[1:0])}))); // R5

  AST_OFF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && cmd_byte_i == 8'h04 && pwr_en_o) |=> (!pwr_en_o && !cpu_rst_n_o)); // R7

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en_o && !(btn_q && !btn_i)) |=> !pwr_en_o); // R7

  AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && cmd_byte_i > 8'h05 && cpu_rst_n_o && !(btn_q && !btn_i)) |=> (cpu_rst_n_o && pwr_en_o)); // R8

  AST_LONG_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_q && !btn_i && hold_cnt >= HOLD_LIM && !cmd_vld_i) |=> (!cpu_rst_n_o && boot_mode_o == MODE_SDP)); // R9

  AST_RELEASE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n_o) |-> pwr_en_o); // R4

  AST_PULSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PULSE) |-> (cnt <= PULSE_LAST)); // R5

endmodule

// File: tb/boot_reset_seq_test.sv
module boot_reset_seq_test;
  localparam int S = 20;
  localparam int P = 5;
  localparam int H = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel_i = 3'b110;
  logic       recov_n_i = 1'b1;
  logic       btn_i = 1'b0;
  logic       cmd_vld_i = 1'b0;
  logic [7:0] cmd_byte_i = 8'h00;
  logic [3:0] boot_mode_o;
  logic       cpu_rst_n_o;
  logic       pwr_en_o;

  int total = 0;
  int bad = 0;

  boot_reset_seq #(.STARTUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) uut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .recov_n_i(recov_n_i), .btn_i(btn_i),
    .cmd_vld_i(cmd_vld_i), .cmd_byte_i(cmd_byte_i), .boot_mode_o(boot_mode_o),
    .cpu_rst_n_o(cpu_rst_n_o), .pwr_en_o(pwr_en_o));

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (!cpu_rst_n_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_vld_i = 1'b1;
    cmd_byte_i = b;
    @(negedge clk);
    cmd_vld_i = 1'b0;
  endtask

  task automatic press(input int cycles);
    @(negedge clk);
    btn_i = 1'b1;
    repeat (cycles) @(negedge clk);
    btn_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_powerup;
    int n;
    repeat (3) @(negedge clk);
    check("R4 reset low in por", cpu_rst_n_o, 0);
    rst_n = 1'b1;
    measure_low(n);
    check("R4 startup low cycles", n, S);
    check("R4 power on", pwr_en_o, 1);
    check("R1 sel 110 mode", boot_mode_o, 4'b0010);
  endtask

  task automatic t_cmd_modes;
    int n;
    for (int c = 0; c < 4; c++) begin
      send_cmd(8'(c));
      measure_low(n);
      check($sformatf("R5 low cycles code %0d", c), n, P + S);
      check($sformatf("R5 mode code %0d", c), boot_mode_o, c);
    end
  endtask

  task automatic t_sel_table;
    int n;
    logic [3:0] exp_tab [8] = '{4'b0000, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0010, 4'b0000};
    for (int s = 0; s < 8; s++) begin
      sel_i = 3'(s);
      send_cmd(8'h05);
      measure_low(n);
      check($sformatf("R6 low cycles sel %0d", s), n, P + S);
      if (s == 1 || s == 4 || s == 5 || s == 6)
        check($sformatf("R1 mode sel %0d", s), boot_mode_o, exp_tab[s]);
      else
        check($sformatf("R2 default mode sel %0d", s), boot_mode_o, exp_tab[s]);
    end
  endtask

  task automatic t_frozen;
    sel_i = 3'b001;
    send_cmd(8'h05);
    wait (cpu_rst_n_o);
    @(negedge clk);
    check("R11 start mode", boot_mode_o, 4'b0011);
    sel_i = 3'b110;
    repeat (4) @(negedge clk);
    check("R11 mode frozen", boot_mode_o, 4'b0011);
    sel_i = 3'b001;
  endtask

  task automatic t_recov;
    int n;
    recov_n_i = 1'b0;
    #1;
    check("R3 override while running", boot_mode_o, 4'b0001);
    recov_n_i = 1'b1;
    #1;
    check("R3 previous mode returns", boot_mode_o, 4'b0011);
    recov_n_i = 1'b0;
    send_cmd(8'h02);
    measure_low(n);
    check("R3 override after cmd", boot_mode_o, 4'b0001);
    recov_n_i = 1'b1;
    #1;
    check("R3 cmd mode under override", boot_mode_o, 4'b0010);
  endtask

  task automatic t_ignored;
    logic [3:0] m;
    int lows = 0;
    m = boot_mode_o;
    send_cmd(8'h06);
    send_cmd(8'hFF);
    send_cmd(8'h80);
    for (int i = 0; i < 6; i++) begin
      if (!cpu_rst_n_o || !pwr_en_o) lows++;
      @(negedge clk);
    end
    check("R8 no reset or power change", lows, 0);
    check("R8 mode unchanged", boot_mode_o, m);
  endtask

  task automatic t_off;
    int n;
    sel_i = 3'b101;
    send_cmd(8'h04);
    check("R7 power dropped", pwr_en_o, 0);
    check("R7 reset low when off", cpu_rst_n_o, 0);
    send_cmd(8'h00);
    repeat (40) @(negedge clk);
    check("R7 command ignored while off", pwr_en_o, 0);
    press(2);
    check("R7 power back", pwr_en_o, 1);
    measure_low(n);
    check("R7 wake low cycles", n, P + S);
    check("R7 wake mode", boot_mode_o, 4'b0001);
  endtask

  task automatic t_button;
    int n;
    sel_i = 3'b110;
    press(H - 1);
    measure_low(n);
    check("R10 short press low cycles", n, P + S);
    check("R10 short press mode", boot_mode_o, 4'b0010);
    press(H);
    measure_low(n);
    check("R9 long press low cycles", n, P + S);
    check("R9 long press mode", boot_mode_o, 4'b0001);
    press(H + 30);
    measure_low(n);
    check("R9 longer press mode", boot_mode_o, 4'b0001);
    send_cmd(8'h05);
    measure_low(n);
    check("R10 select mode after cmd", boot_mode_o, 4'b0010);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_powerup();
    t_cmd_modes();
    t_sel_table();
    t_frozen();
    t_recov();
    t_ignored();
    t_off();
    t_button();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule